// File: doc/BRIEF.md
# Nonvolatile Memory Command Decoder

This block models the command front end of a byte-wide memory whose cells can be cleared one byte at a time and restored in bulk. A host drives an asynchronous-style bus with active-low chip select, output enable and write enable, an address and a data byte. The bus signals are sampled on a system clock. Each completed write cycle is decoded as a command byte, or as program data when a program set-up is pending. The decoded command selects what the read port returns: the array at the bus address, the byte chosen by an erase verify, or the byte just programmed.

Changing the array always takes two writes. Programming needs a set-up byte followed by the address and data. Erasing needs the same erase byte written twice in a row. A separate high-voltage enable input must be asserted before any write is accepted. While that input is low, the block stays in array read mode. The array is a small register memory indexed by the low address bits. A busy output marks the interval from the start of a program or erase operation to the next write.

Top module: `nvm_cmd_top`

## Requirements
- R1: After reset the block is in array read mode, busy is low and every array byte reads 8'hFF.
- R2: dataOe is high only while chipEn_n and outEn_n are low and wrEn_n is high. In array read mode, dataOut equals the byte at index busAddr[ARR_AW-1:0].
- R3: A write completes on a clock where wrEn_n is seen rising while chipEn_n is low. Its address is the bus address sampled when wrEn_n was seen falling with chipEn_n low. Its data is dataIn sampled at the rise. A write with chipEn_n high changes nothing.
- R4: While hvEnable is low, every write is ignored and the block returns to array read mode.
- R5: Command 8'h40 enters program set-up. The next write programs its latched address: the stored byte becomes old AND data, and busy goes high.
- R6: An active program ends at the next write, which is decoded as a command. Command 8'hC0 selects program verify, where dataOut shows the last programmed byte whatever the bus address is.
- R7: In program set-up, a first 8'hFF is taken as data that clears no bits. A second 8'hFF returns the block to array read mode.
- R8: Writing 8'h20 twice in a row sets every array byte to 8'hFF and raises busy until the next write.
- R9: After one 8'h20, any other byte cancels the erase, leaves the array untouched and returns to array read mode.
- R10: Command 8'hA0 selects erase verify. dataOut then shows the byte at the address latched with that A0 write.
- R11: Commands 8'h00 and 8'hFF, and every byte not listed above, select array read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| chipEn_n | input | 1 | Active-low chip select |
| outEn_n | input | 1 | Active-low output enable |
| wrEn_n | input | 1 | Active-low write strobe |
| busAddr | input | 17 | Byte address |
| dataIn | input | 8 | Write data or command byte |
| hvEnable | input | 1 | Write permission (high voltage present) |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Drive enable for dataOut (low means tri-state) |
| busy | output | 1 | Program or erase operation in progress |

## Verification
A decoder stuck in the wrong state shows up on the read port at the first read after the next write. Program verify and erase verify ignore the bus address, so a wrong mode returns a byte from another location. A missed or extra strobe leaves the array in a state a later readback exposes: a bit set where only clears are allowed, a byte not restored to FF, or an erase that happened after a cancel. Busy is compared after every write in the sequences, so a late or missing transition out of an active state is seen within one write cycle.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

  localparam logic [7:0] CMD_ARRAY_READ = 8'h00;
  localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_ERASE_VFY  = 8'hA0;
  localparam logic [7:0] CMD_PGM_VFY    = 8'hC0;
  localparam logic [7:0] CMD_ABORT      = 8'hFF;

  typedef enum logic [2:0] {
    MODE_READ,
    MODE_PGM_SETUP,
    MODE_PGM_BUSY,
    MODE_ERASE_SETUP,
    MODE_ERASE_BUSY,
    MODE_ERASE_VFY,
    MODE_PGM_VFY
  } modeT;

  typedef enum logic [1:0] {
    SRC_BUS,
    SRC_LATCHED,
    SRC_PROGRAMMED
  } readSrcT;

  typedef struct packed {
    logic    capAddr;
    logic    pgmStb;
    logic    eraseStb;
    readSrcT readSrc;
  } ctrlStrobesT;

endpackage

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chipEn_n,
  input  logic              wrEn_n,
  input  logic              hvEnable,
  input  logic [DATA_W-1:0] dataIn,
  output ctrlStrobesT       strb,
  output logic              busy
);

  logic weQ;
  modeT modeQ, modeD;
  logic weFall, weRise, writeOk;
  logic pgmGo, eraseGo;

  // previous write strobe level, used to find its edges on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) weQ <= 1'b1;
    else        weQ <= wrEn_n;
  end

  assign weFall  = weQ & ~wrEn_n & ~chipEn_n;
  assign weRise  = ~weQ & wrEn_n & ~chipEn_n;
  assign writeOk = weRise & hvEnable;

  function automatic modeT decodeCmd(input logic [DATA_W-1:0] cmd);
    case (cmd[7:0])
      CMD_PGM_SETUP: return MODE_PGM_SETUP;
      CMD_ERASE:     return MODE_ERASE_SETUP;
      CMD_ERASE_VFY: return MODE_ERASE_VFY;
      CMD_PGM_VFY:   return MODE_PGM_VFY;
      default:       return MODE_READ;
    endcase
  endfunction

  always_comb begin
    modeD   = modeQ;
    pgmGo   = 1'b0;
    eraseGo = 1'b0;
    if (!hvEnable) begin
      modeD = MODE_READ;
    end else if (weRise) begin
      case (modeQ)
        MODE_PGM_SETUP: begin
          pgmGo = 1'b1;
          modeD = MODE_PGM_BUSY;
        end
        MODE_ERASE_SETUP: begin
          if (dataIn[7:0] == CMD_ERASE) begin
            eraseGo = 1'b1;
            modeD   = MODE_ERASE_BUSY;
          end else begin
            modeD = MODE_READ;
          end
        end
        default: modeD = decodeCmd(dataIn);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modeQ <= MODE_READ;
    else        modeQ <= modeD;
  end

  always_comb begin
    strb.capAddr  = weFall & hvEnable;
    strb.pgmStb   = pgmGo;
    strb.eraseStb = eraseGo;
    strb.readSrc  = SRC_BUS;
    if (hvEnable) begin
      if (modeQ == MODE_ERASE_VFY)    strb.readSrc = SRC_LATCHED;
      else if (modeQ == MODE_PGM_VFY) strb.readSrc = SRC_PROGRAMMED;
    end
  end

  assign busy = (modeQ == MODE_PGM_BUSY) || (modeQ == MODE_ERASE_BUSY);

  assert_hv_low_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hvEnable |=> (modeQ == MODE_READ));

  assert_busy_after_pgm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.pgmStb || strb.eraseStb) |=> busy);

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.pgmStb, strb.eraseStb}));

  assert_abort_twice_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_PGM_BUSY && writeOk && dataIn[7:0] == CMD_ABORT) |=> (modeQ == MODE_READ));

  assert_erase_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_ERASE_SETUP && writeOk && dataIn[7:0] != CMD_ERASE) |=> (modeQ == MODE_READ && !busy));

endmodule

// File: rtl/nvm_cmd_array.sv
module nvm_cmd_array
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobesT       strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [DATA_W-1:0] memQ [DEPTH];
  logic [ARR_AW-1:0] latAddrQ, pgmAddrQ, busIdx, rdIdx;
  logic              unusedHighAddr;

  assign busIdx = busAddr[ARR_AW-1:0];

  generate
    if (ADDR_W > ARR_AW) begin : g_hi
      assign unusedHighAddr = ^busAddr[ADDR_W-1:ARR_AW];
    end else begin : g_nohi
      assign unusedHighAddr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latAddrQ <= '0;
      pgmAddrQ <= '0;
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '1;
    end else begin
      if (strb.capAddr) latAddrQ <= busIdx;
      if (strb.eraseStb) begin
        for (int i = 0; i < DEPTH; i++) memQ[i] <= '1;
      end else if (strb.pgmStb) begin
        memQ[latAddrQ] <= memQ[latAddrQ] & dataIn;
        pgmAddrQ       <= latAddrQ;
      end
    end
  end

  always_comb begin
    case (strb.readSrc)
      SRC_LATCHED:    rdIdx = latAddrQ;
      SRC_PROGRAMMED: rdIdx = pgmAddrQ;
      default:        rdIdx = busIdx;
    endcase
  end

  assign rdData = memQ[rdIdx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      assert_only_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.eraseStb |=> ((memQ[g] & ~$past(memQ[g])) == '0));
      assert_erase_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strb.eraseStb |=> (memQ[g] == '1));
    end
  endgenerate

endmodule

// File: rtl/nvm_cmd_top.sv
module nvm_cmd_top
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chipEn_n,
  input  logic              outEn_n,
  input  logic              wrEn_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              hvEnable,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy
);

  ctrlStrobesT strb;

  nvm_cmd_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chipEn_n(chipEn_n), .wrEn_n(wrEn_n),
    .hvEnable(hvEnable), .dataIn(dataIn), .strb(strb), .busy(busy)
  );

  nvm_cmd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busAddr(busAddr),
    .dataIn(dataIn), .rdData(dataOut)
  );

  assign dataOe = ~chipEn_n & ~outEn_n & wrEn_n;

endmodule

// File: tb/sim_nvm_cmd_top.sv
module sim_nvm_cmd_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chipEn_n = 1'b1, outEn_n = 1'b1, wrEn_n = 1'b1, hvEnable = 1'b0;
  logic [16:0] busAddr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] model [16];

  always #5 clk = ~clk;

  nvm_cmd_top u0 (
    .clk(clk), .rst_n(rst_n), .chipEn_n(chipEn_n), .outEn_n(outEn_n),
    .wrEn_n(wrEn_n), .busAddr(busAddr), .dataIn(dataIn), .hvEnable(hvEnable),
    .dataOut(dataOut), .dataOe(dataOe), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  // bus write: address a at the falling strobe, a2 while it rises
  task automatic wr(input logic [16:0] a, input logic [16:0] a2, input logic [7:0] d, input bit sel);
    @(negedge clk);
    busAddr = a; dataIn = d; chipEn_n = ~sel; outEn_n = 1'b1; wrEn_n = 1'b0;
    @(negedge clk);
    busAddr = a2; wrEn_n = 1'b1;
    @(negedge clk);
    chipEn_n = 1'b1;
  endtask

  task automatic rdChk(input string req, input logic [16:0] a, input logic [7:0] exp);
    @(negedge clk);
    busAddr = a; chipEn_n = 1'b0; outEn_n = 1'b0; wrEn_n = 1'b1;
    #1;
    chk(req, {7'b0, dataOe}, 8'h01);
    chk(req, dataOut, exp);
    chipEn_n = 1'b1; outEn_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {7'b0, busy}, 8'h00);
    chk("R2 oe with chip deselected", {7'b0, dataOe}, 8'h00);
    for (int i = 0; i < 16; i++) rdChk("R1 erased at reset", 17'(i), 8'hFF);
    // R2 output enable high keeps outputs off
    @(negedge clk); chipEn_n = 1'b0; outEn_n = 1'b1; #1;
    chk("R2 oe with OE high", {7'b0, dataOe}, 8'h00);
    chipEn_n = 1'b1;

    // R4 writes ignored without high voltage
    wr(17'd3, 17'd3, 8'h20, 1'b1);
    wr(17'd3, 17'd3, 8'h20, 1'b1);
    chk("R4 busy", {7'b0, busy}, 8'h00);
    hvEnable = 1'b1;

    // R5 R6 program sweep with verify
    for (int i = 0; i < 16; i++) begin
      logic [7:0] pat;
      pat = 8'((i * 37 + 11) ^ 8'hA5);
      wr(17'(i), 17'(i), 8'h40, 1'b1);
      wr(17'(i) | 17'h10000, 17'(i), pat, 1'b1);
      model[i] = model[i] & pat;
      chk("R5 busy after program", {7'b0, busy}, 8'h01);
      wr(17'((i + 5) % 16), 17'((i + 5) % 16), 8'hC0, 1'b1);
      chk("R6 busy ends at next write", {7'b0, busy}, 8'h00);
      rdChk("R6 program verify", 17'((i + 9) % 16), model[i]);
    end
    // second pass: AND with a different pattern, then read in array mode
    for (int i = 0; i < 16; i++) begin
      logic [7:0] pat;
      pat = 8'(~(i * 53 + 7));
      wr(17'(i), 17'(i), 8'h40, 1'b1);
      wr(17'(i), 17'(i), pat, 1'b1);
      model[i] = model[i] & pat;
      wr(17'd0, 17'd0, 8'h00, 1'b1);
    end
    for (int i = 0; i < 16; i++) rdChk("R5 old AND data", 17'(i), model[i]);

    // R3 address taken at the falling strobe
    wr(17'd3, 17'd3, 8'h40, 1'b1);
    wr(17'd3, 17'd9, 8'h0F, 1'b1);
    model[3] = model[3] & 8'h0F;
    wr(17'd0, 17'd0, 8'h00, 1'b1);
    rdChk("R3 falling-edge address", 17'd3, model[3]);
    rdChk("R3 rising-edge address untouched", 17'd9, model[9]);
    // R3 deselected write
    wr(17'd0, 17'd0, 8'h20, 1'b0);
    wr(17'd0, 17'd0, 8'h20, 1'b0);
    chk("R3 deselected busy", {7'b0, busy}, 8'h00);
    rdChk("R3 deselected no erase", 17'd5, model[5]);

    // R4 high voltage drop cancels a pending set-up
    wr(17'd2, 17'd2, 8'h40, 1'b1);
    @(negedge clk); hvEnable = 1'b0;
    @(negedge clk); hvEnable = 1'b1;
    wr(17'd2, 17'd2, 8'h00, 1'b1);
    chk("R4 no program after drop", {7'b0, busy}, 8'h00);
    rdChk("R4 setup cancelled", 17'd2, model[2]);

    // R7 double abort
    wr(17'd4, 17'd4, 8'h40, 1'b1);
    wr(17'd4, 17'd4, 8'hFF, 1'b1);
    chk("R7 first FF is data", {7'b0, busy}, 8'h01);
    wr(17'd4, 17'd4, 8'hFF, 1'b1);
    chk("R7 second FF aborts", {7'b0, busy}, 8'h00);
    rdChk("R7 null data", 17'd4, model[4]);
    rdChk("R7 read mode", 17'd7, model[7]);

    // R9 erase cancel
    wr(17'd0, 17'd0, 8'h20, 1'b1);
    wr(17'd0, 17'd0, 8'h00, 1'b1);
    chk("R9 cancel busy", {7'b0, busy}, 8'h00);
    for (int i = 0; i < 16; i++) rdChk("R9 array kept", 17'(i), model[i]);

    // R10 erase verify, R11 unknown command
    wr(17'd6, 17'd6, 8'hA0, 1'b1);
    rdChk("R10 verify latched address", 17'd1, model[6]);
    wr(17'd0, 17'd0, 8'h55, 1'b1);
    rdChk("R11 unknown byte reads array", 17'd1, model[1]);
    wr(17'd0, 17'd0, 8'hC0, 1'b1);
    wr(17'd0, 17'd0, 8'hFF, 1'b1);
    rdChk("R11 FF reads array", 17'd8, model[8]);

    // R8 bulk erase
    wr(17'd0, 17'd0, 8'h20, 1'b1);
    wr(17'd0, 17'd0, 8'h20, 1'b1);
    chk("R8 busy during erase", {7'b0, busy}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      wr(17'(i), 17'(i), 8'hA0, 1'b1);
      chk("R8 busy cleared", {7'b0, busy}, 8'h00);
      rdChk("R8 erased byte", 17'((i + 3) % 16), 8'hFF);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule